// File: doc/BRIEF.md
# Palette DAC Port Sequencer

This block holds a 256-entry colour look-up table whose entries each carry three 6-bit components (red, green, blue). Software programs and inspects the table one byte at a time through three small ports: a port that sets the index used for reading back, a port that sets the index used for loading, and a data port. Every table entry takes three data accesses, one per component, in the order red, green, blue. A two-bit component counter selects the component and is shared by the read and load directions. The loading index and the reading index each advance on their own after every third access.

Bytes written to the data port are collected in a holding buffer. The entry is updated only when its third byte arrives, so a triplet that is broken off by an index write never reaches the table. A second, independent port lets the display side fetch any entry as a 24-bit colour. Each component is widened from 6 to 8 bits by replicating its least significant bit into the two new low bits.

Top module: `palette_dac_seq`

## Requirements
- R1: A write to the read-index port (acc_sel = 0) loads the read index from wdata, clears the component counter and sets the mode state to 3; a later read of port 0 returns the mode state zero-extended.
- R2: A write to the write-index port (acc_sel = 1) loads the write index, clears the component counter and sets the mode state to 0; a read of port 1 returns the current write index.
- R3: Data-port writes (acc_sel = 2) are staged by component (0 = red, 1 = green, 2 = blue) and keep only wdata[5:0]. On the third write, all three components are written to the entry at the write index, the counter returns to 0 and the write index increments, wrapping from 255 to 0.
- R4: A data-port read returns, in rdata[5:0] with rdata[7:6] zero, the component selected by the counter of the entry at the read index. After the third read, the read index increments, wrapping from 255 to 0.
- R5: A write to either index port in the middle of a triplet discards the staged bytes, and the table entry being loaded keeps its old value.
- R6: col_rgb presents the entry addressed by col_idx one clock later as {red, green, blue}, 8 bits each with red in bits 23:16. Each 6-bit component v is widened to {v, v[0], v[0]}.
- R7: If col_idx addresses an entry in the same cycle that the entry is committed, col_rgb shows the old contents in the next cycle and the new contents one cycle after that.
- R8: Writes to acc_sel = 3 change nothing, including a triplet in progress, and reads of acc_sel = 3 return 0.
- R9: After reset both indices, the component counter and the mode state are 0, all table entries are 0, and col_rgb is 0.
- R10: The component counter is shared by both directions: a data read that follows one data write without an intervening index write returns component 1 of the entry at the read index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A byte access is performed this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_sel | input | 2 | Port select: 0 read index / mode, 1 write index, 2 data, 3 unused |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Result of the most recent read access, registered |
| col_idx | input | 8 | Table entry requested by the colour port |
| col_rgb | output | 24 | Widened colour of the entry requested one cycle earlier |

## Verification
The assertions assume that acc_sel, acc_write and wdata are stable and known whenever acc_valid is high, and that at most one access happens per cycle. They also take the mode state to be only ever 0 or 3. The stimulus drives every access for exactly one cycle, away from the active edge, and inserts an idle cycle between accesses. Index writes are the only way the bench restarts a triplet, so the component counter is always in the intended phase when a data access is issued.

// File: rtl/dac_pkg.sv
package dac_pkg;

    // Port selector for the byte access interface
    typedef enum logic [1:0] {
        DAC_PORT_RIDX = 2'd0,
        DAC_PORT_WIDX = 2'd1,
        DAC_PORT_DATA = 2'd2,
        DAC_PORT_NONE = 2'd3
    } dac_port_e;

    // Mode state reported on port 0
    typedef enum logic [1:0] {
        DAC_MODE_WR = 2'd0,
        DAC_MODE_RD = 2'd3
    } dac_mode_e;

    // Components per entry and the counter value of the last one
    localparam int          DAC_NCOMP   = 3;
    localparam logic [1:0]  DAC_SUB_LAST = 2'd2;

endpackage

// File: rtl/dac_port_ctrl.sv
module dac_port_ctrl
    import dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    parameter int BUS_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        acc_valid,
    input  logic                        acc_write,
    input  logic [1:0]                  acc_sel,
    input  logic [BUS_W-1:0]            wdata,
    output logic [IDX_W-1:0]            ridx,
    output logic [IDX_W-1:0]            widx,
    output logic [1:0]                  sub,
    output dac_mode_e                   mode,
    output logic                        commit_en,
    output logic [DAC_NCOMP*COMP_W-1:0] commit_data
);

    logic [COMP_W-1:0] hold_q [2];
    logic              wr_acc;
    logic              rd_acc;
    logic              last_comp;

    assign wr_acc    = acc_valid &  acc_write;
    assign rd_acc    = acc_valid & ~acc_write;
    assign last_comp = (sub == DAC_SUB_LAST);

    assign commit_en   = wr_acc && (acc_sel == DAC_PORT_DATA) && last_comp;
    assign commit_data = {hold_q[0], hold_q[1], wdata[COMP_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ridx      <= '0;
            widx      <= '0;
            sub       <= 2'd0;
            mode      <= DAC_MODE_WR;
            hold_q[0] <= '0;
            hold_q[1] <= '0;
        end else if (wr_acc) begin
            case (acc_sel)
                DAC_PORT_RIDX: begin
                    ridx <= wdata[IDX_W-1:0];
                    sub  <= 2'd0;
                    mode <= DAC_MODE_RD;
                end
                DAC_PORT_WIDX: begin
                    widx <= wdata[IDX_W-1:0];
                    sub  <= 2'd0;
                    mode <= DAC_MODE_WR;
                end
                DAC_PORT_DATA: begin
                    if (last_comp) begin
                        sub  <= 2'd0;
                        widx <= widx + 1'b1;
                    end else begin
                        hold_q[sub[0]] <= wdata[COMP_W-1:0];
                        sub            <= sub + 2'd1;
                    end
                end
                default: ;
            endcase
        end else if (rd_acc && (acc_sel == DAC_PORT_DATA)) begin
            if (last_comp) begin
                sub  <= 2'd0;
                ridx <= ridx + 1'b1;
            end else begin
                sub <= sub + 2'd1;
            end
        end
    end

endmodule

// File: rtl/dac_palette_mem.sv
module dac_palette_mem
    import dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [IDX_W-1:0]            waddr,
    input  logic [DAC_NCOMP*COMP_W-1:0] wentry,
    input  logic [IDX_W-1:0]            raddr_a,
    output logic [DAC_NCOMP*COMP_W-1:0] rentry_a,
    input  logic [IDX_W-1:0]            raddr_b,
    output logic [DAC_NCOMP*COMP_W-1:0] rentry_b
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int EW    = DAC_NCOMP * COMP_W;

    logic [EW-1:0] table_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                table_q[i] <= '0;
            end
        end else if (we) begin
            table_q[waddr] <= wentry;
        end
    end

    // Bus side: combinational, registered by the caller
    assign rentry_a = table_q[raddr_a];

    // Display side: synchronous, sees pre-write contents on a collision
    always_ff @(posedge clk) begin
        if (rst) begin
            rentry_b <= '0;
        end else begin
            rentry_b <= table_q[raddr_b];
        end
    end

endmodule

// File: rtl/dac_widen.sv
module dac_widen
    import dac_pkg::*;
#(
    parameter int COMP_W = 6,
    parameter int OUT_W  = 8
) (
    input  logic [DAC_NCOMP*COMP_W-1:0] entry,
    output logic [DAC_NCOMP*OUT_W-1:0]  colour
);

    localparam int PAD_W = OUT_W - COMP_W;

    for (genvar c = 0; c < DAC_NCOMP; c++) begin : g_comp
        logic [COMP_W-1:0] v;
        assign v = entry[c*COMP_W +: COMP_W];
        assign colour[c*OUT_W +: OUT_W] = {v, {PAD_W{v[0]}}};
    end

endmodule

// File: rtl/palette_dac_seq.sv
module palette_dac_seq
    import dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    parameter int OUT_W  = 8,
    parameter int BUS_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       acc_valid,
    input  logic                       acc_write,
    input  logic [1:0]                 acc_sel,
    input  logic [BUS_W-1:0]           wdata,
    output logic [BUS_W-1:0]           rdata,
    input  logic [IDX_W-1:0]           col_idx,
    output logic [DAC_NCOMP*OUT_W-1:0] col_rgb
);

    localparam int EW = DAC_NCOMP * COMP_W;

    logic [IDX_W-1:0] ridx;
    logic [IDX_W-1:0] widx;
    logic [1:0]       sub;
    dac_mode_e        mode;
    logic             commit_en;
    logic [EW-1:0]    commit_data;
    logic [EW-1:0]    bus_entry;
    logic [EW-1:0]    disp_entry;
    logic [COMP_W-1:0] bus_comp;
    logic [BUS_W-1:0] rd_next;

    dac_port_ctrl #(
        .IDX_W (IDX_W),
        .COMP_W(COMP_W),
        .BUS_W (BUS_W)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_sel    (acc_sel),
        .wdata      (wdata),
        .ridx       (ridx),
        .widx       (widx),
        .sub        (sub),
        .mode       (mode),
        .commit_en  (commit_en),
        .commit_data(commit_data)
    );

    dac_palette_mem #(
        .IDX_W (IDX_W),
        .COMP_W(COMP_W)
    ) mem_i (
        .clk     (clk),
        .rst     (rst),
        .we      (commit_en),
        .waddr   (widx),
        .wentry  (commit_data),
        .raddr_a (ridx),
        .rentry_a(bus_entry),
        .raddr_b (col_idx),
        .rentry_b(disp_entry)
    );

    dac_widen #(
        .COMP_W(COMP_W),
        .OUT_W (OUT_W)
    ) widen_i (
        .entry (disp_entry),
        .colour(col_rgb)
    );

    // Component 0 is red, held in the top field of an entry
    always_comb begin
        case (sub)
            2'd0:    bus_comp = bus_entry[2*COMP_W +: COMP_W];
            2'd1:    bus_comp = bus_entry[COMP_W +: COMP_W];
            default: bus_comp = bus_entry[0 +: COMP_W];
        endcase
    end

    always_comb begin
        case (acc_sel)
            DAC_PORT_RIDX: rd_next = BUS_W'(mode);
            DAC_PORT_WIDX: rd_next = BUS_W'(widx);
            DAC_PORT_DATA: rd_next = BUS_W'(bus_comp);
            default:       rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (acc_valid && !acc_write) begin
            rdata <= rd_next;
        end
    end

endmodule

// File: rtl/dac_seq_checker.sv
module dac_seq_checker
    import dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    parameter int OUT_W  = 8,
    parameter int BUS_W  = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       acc_valid,
    input logic                       acc_write,
    input logic [1:0]                 acc_sel,
    input logic [BUS_W-1:0]           rdata,
    input logic [DAC_NCOMP*OUT_W-1:0] col_rgb,
    input logic [IDX_W-1:0]           ridx,
    input logic [IDX_W-1:0]           widx,
    input logic [1:0]                 sub,
    input logic [1:0]                 mode
);

    localparam int PAD_W = OUT_W - COMP_W;

    logic wr_data;
    assign wr_data = acc_valid && acc_write && (acc_sel == DAC_PORT_DATA);

    p_sub_bound_r3: assert property (@(posedge clk) disable iff (rst)
        sub != 2'd3);

    p_widx_step_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_data && sub == DAC_SUB_LAST) |=> (widx == $past(widx) + 1'b1) && (sub == 2'd0));

    p_ridx_load_r1: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_sel == DAC_PORT_RIDX) |=> (mode == DAC_MODE_RD) && (sub == 2'd0));

    p_widx_load_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_sel == DAC_PORT_WIDX) |=> (mode == DAC_MODE_WR) && (sub == 2'd0));

    p_data_hi_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_sel == DAC_PORT_DATA) |=> (rdata[BUS_W-1:COMP_W] == '0));

    p_unused_port_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_sel == DAC_PORT_NONE)
        |=> $stable(widx) && $stable(ridx) && $stable(sub) && $stable(mode));

    for (genvar c = 0; c < DAC_NCOMP; c++) begin : g_wid
        p_widen_lsb_r6: assert property (@(posedge clk) disable iff (rst)
            col_rgb[c*OUT_W +: PAD_W] == {PAD_W{col_rgb[c*OUT_W + PAD_W]}});
    end

endmodule

bind palette_dac_seq dac_seq_checker #(
    .IDX_W (IDX_W),
    .COMP_W(COMP_W),
    .OUT_W (OUT_W),
    .BUS_W (BUS_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .acc_sel  (acc_sel),
    .rdata    (rdata),
    .col_rgb  (col_rgb),
    .ridx     (ridx),
    .widx     (widx),
    .sub      (sub),
    .mode     (mode)
);

// File: tb/palette_dac_seq_tb_top.sv
`timescale 1ns/1ps
module palette_dac_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_sel = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic [7:0]  col_idx = 8'd0;
    logic [23:0] col_rgb;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [17:0] exp_tab [256];

    always #4 clk = ~clk;

    palette_dac_seq dut_i (
        .clk      (clk),
        .rst      (rst),
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .acc_sel  (acc_sel),
        .wdata    (wdata),
        .rdata    (rdata),
        .col_idx  (col_idx),
        .col_rgb  (col_rgb)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wid(input logic [5:0] v);
        return 8'(v) * 8'd4 + 8'(v[0]) * 8'd3;
    endfunction

    function automatic logic [23:0] wid_entry(input logic [17:0] e);
        return {wid(e[17:12]), wid(e[11:6]), wid(e[5:0])};
    endfunction

    function automatic logic [7:0] pat(input int i, input int c);
        return 8'((i * 5 + c * 23 + 3) & 63) | 8'hC0;
    endfunction

    task automatic acc(input logic [1:0] sel, input logic wr, input logic [7:0] d,
                       output logic [7:0] q);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = wr;
        acc_sel   = sel;
        wdata     = d;
        @(negedge clk);
        acc_valid = 1'b0;
        q = rdata;
    endtask

    task automatic colour_check(input string tag, input int idx);
        @(negedge clk);
        col_idx = 8'(idx);
        @(negedge clk);
        check(tag, 32'(col_rgb), 32'(wid_entry(exp_tab[idx])));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        for (int i = 0; i < 256; i++) exp_tab[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        acc(2'd0, 1'b0, 8'h00, q); check("R9 mode after reset", 32'(q), 32'd0);
        acc(2'd1, 1'b0, 8'h00, q); check("R9 widx after reset", 32'(q), 32'd0);
        colour_check("R9 entry 0 after reset", 0);
        colour_check("R9 entry 255 after reset", 255);

        // R3: load every entry
        acc(2'd1, 1'b1, 8'd0, q);
        for (int i = 0; i < 256; i++) begin
            for (int c = 0; c < 3; c++) begin
                acc(2'd2, 1'b1, pat(i, c), q);
            end
            exp_tab[i] = {pat(i, 0)[5:0], pat(i, 1)[5:0], pat(i, 2)[5:0]};
        end
        acc(2'd1, 1'b0, 8'h00, q); check("R3 widx wraps to 0", 32'(q), 32'd0);
        acc(2'd0, 1'b0, 8'h00, q); check("R2 mode after widx write", 32'(q), 32'd0);

        // R1/R4: read every entry back
        acc(2'd0, 1'b1, 8'd0, q);
        acc(2'd0, 1'b0, 8'h00, q); check("R1 mode after ridx write", 32'(q), 32'd3);
        for (int i = 0; i < 256; i++) begin
            for (int c = 0; c < 3; c++) begin
                acc(2'd2, 1'b0, 8'h00, q);
                check($sformatf("R4 read entry %0d comp %0d", i, c), 32'(q),
                      32'(exp_tab[i][(2-c)*6 +: 6]));
            end
        end
        acc(2'd2, 1'b0, 8'h00, q);
        check("R4 ridx wraps to 0", 32'(q), 32'(exp_tab[0][17:12]));
        acc(2'd0, 1'b1, 8'd0, q);

        // R6: colour port over every entry
        for (int i = 0; i < 256; i++) begin
            colour_check($sformatf("R6 colour entry %0d", i), i);
        end

        // R5: broken triplet discarded
        acc(2'd1, 1'b1, 8'd5, q);
        acc(2'd2, 1'b1, 8'h11, q);
        acc(2'd2, 1'b1, 8'h22, q);
        acc(2'd1, 1'b1, 8'd9, q);
        acc(2'd1, 1'b0, 8'h00, q); check("R2 widx readback", 32'(q), 32'd9);
        colour_check("R5 entry 5 unchanged", 5);
        acc(2'd2, 1'b1, 8'h01, q);
        acc(2'd2, 1'b1, 8'h02, q);
        acc(2'd2, 1'b1, 8'h03, q);
        exp_tab[9] = {6'h01, 6'h02, 6'h03};
        colour_check("R5 fresh triplet after restart", 9);

        // R5 on read side: ridx write restarts component
        acc(2'd0, 1'b1, 8'd7, q);
        acc(2'd2, 1'b0, 8'h00, q); check("R4 entry 7 comp 0", 32'(q), 32'(exp_tab[7][17:12]));
        acc(2'd0, 1'b1, 8'd8, q);
        acc(2'd2, 1'b0, 8'h00, q); check("R5 read restart comp 0", 32'(q), 32'(exp_tab[8][17:12]));

        // R10: shared component counter
        acc(2'd0, 1'b1, 8'd30, q);
        acc(2'd1, 1'b1, 8'd40, q);
        acc(2'd2, 1'b1, 8'h3F, q);
        acc(2'd2, 1'b0, 8'h00, q); check("R10 shared counter", 32'(q), 32'(exp_tab[30][11:6]));
        acc(2'd1, 1'b1, 8'd40, q);
        colour_check("R5 entry 40 unchanged", 40);

        // R3: wrap of write index
        acc(2'd1, 1'b1, 8'd255, q);
        acc(2'd2, 1'b1, 8'h2A, q);
        acc(2'd2, 1'b1, 8'h15, q);
        acc(2'd2, 1'b1, 8'hFF, q);
        exp_tab[255] = {6'h2A, 6'h15, 6'h3F};
        acc(2'd1, 1'b0, 8'h00, q); check("R3 widx 255 wraps", 32'(q), 32'd0);
        colour_check("R3 entry 255 committed", 255);

        // R7: collision between commit and colour read
        acc(2'd1, 1'b1, 8'd100, q);
        acc(2'd2, 1'b1, 8'h07, q);
        acc(2'd2, 1'b1, 8'h08, q);
        @(negedge clk);
        col_idx   = 8'd100;
        acc_valid = 1'b1; acc_write = 1'b1; acc_sel = 2'd2; wdata = 8'h09;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R7 old value on collision", 32'(col_rgb), 32'(wid_entry(exp_tab[100])));
        exp_tab[100] = {6'h07, 6'h08, 6'h09};
        @(negedge clk);
        check("R7 new value next cycle", 32'(col_rgb), 32'(wid_entry(exp_tab[100])));

        // R8: unused port
        acc(2'd1, 1'b1, 8'd50, q);
        acc(2'd2, 1'b1, 8'h21, q);
        acc(2'd3, 1'b1, 8'h55, q);
        acc(2'd2, 1'b1, 8'h22, q);
        acc(2'd2, 1'b1, 8'h23, q);
        exp_tab[50] = {6'h21, 6'h22, 6'h23};
        colour_check("R8 triplet unaffected by unused port", 50);
        acc(2'd1, 1'b0, 8'h00, q); check("R8 widx unaffected", 32'(q), 32'd51);
        acc(2'd0, 1'b0, 8'h00, q); check("R8 mode unaffected", 32'(q), 32'd0);
        acc(2'd3, 1'b0, 8'h00, q); check("R8 unused port reads 0", 32'(q), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule